// File: doc/BRIEF.md
# Address-Generation and Single-Bit ALU

This block is a purely combinational execute-stage unit for two groups of bit-manipulation operations. The first group computes addresses by shifting one operand left by one, two or three places and adding the other. Some of these operations first reduce the shifted operand to its zero-extended low 32-bit word. The second group reads or changes one bit of the first operand. The bit index comes from the second operand or from an immediate shift amount.

The unit is built for a 32-bit or a 64-bit datapath, chosen by the `XLEN` parameter. The instruction decoder supplies a 5-bit operation code and the two register operands. For immediate forms it also supplies the 6-bit shift-amount field. The unit returns the result and a flag marking an immediate encoding that is reserved on a 32-bit datapath.

Top module: `bitmanip_agu`

## Requirements
- R1: Operation codes 1, 2 and 3 return `src_b + (src_a << N)` with N equal to the code, truncated to XLEN bits.
- R2: Codes 4, 5 and 6 take the low 32 bits of `src_a` zero-extended to XLEN and shift them left by 1, 2 and 3. They then add `src_b` at full XLEN width.
- R3: Code 0 returns `src_b` plus the zero-extended low 32-bit word of `src_a`.
- R4: Code 7 returns the zero-extended low word of `src_a` shifted left by the low log2(XLEN) bits of `imm_amt`.
- R5: Codes 8, 9 and 10 (register index) and 12, 13 and 14 (immediate index) return `src_a` with one bit cleared, set or inverted respectively.
- R6: Codes 11 (register index) and 15 (immediate index) return the selected bit of `src_a` in bit 0 and zeros in every other bit.
- R7: The bit index is taken only from the low log2(XLEN) bits of `src_b` for register forms, or of `imm_amt` for immediate forms. Higher bits of the index source have no effect.
- R8: When XLEN is 32, an immediate form (codes 7, 12, 13, 14, 15) with `imm_amt[5]` set raises `reserved_enc`, and `result` is zero. Register forms never raise the flag.
- R9: Codes 16 to 31 give a zero result with `reserved_enc` clear.
- R10: When XLEN is 64, `imm_amt[5]` is a normal index and shift bit, and `reserved_enc` stays clear for every code.
- R11: When XLEN is 32, codes 4, 5 and 6 give the same result as codes 1, 2 and 3, and code 0 gives a plain sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 5 | Operation code (0 to 15 defined, 16 to 31 unknown) |
| src_a | input | XLEN | First register operand |
| src_b | input | XLEN | Second register operand, also the register-form bit index |
| imm_amt | input | 6 | Immediate shift amount or bit index |
| result | output | XLEN | Operation result |
| reserved_enc | output | 1 | Reserved immediate encoding on a 32-bit datapath |

## Verification
The same stimulus drives a 64-bit and a 32-bit instance. The bench predicts each instance's output separately. Operands with ones above bit 31 separate the zero-extending forms from the plain ones on the wide instance, and the same operands show that the two families agree on the narrow instance. Shift results that carry past bit 31 or wrap past the top bit catch truncation errors. Bit indices above 31, and index sources with high bits set, separate correct masking from the use of extra bits. Immediates with bit 5 set are checked as a real index or shift on the wide instance and as a reserved encoding on the narrow one.

// File: rtl/bitmanip_agu.sv
module bitmanip_agu #(
  parameter int XLEN = 32
) (
  input  logic [4:0]      op_sel,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [5:0]      imm_amt,
  output logic [XLEN-1:0] result,
  output logic            reserved_enc
);
  localparam int IDXW = $clog2(XLEN);
  localparam bit NARROW = (XLEN == 32);
  localparam logic [XLEN-1:0] LOW_MASK = XLEN'(64'h0000_0000_FFFF_FFFF);

  localparam logic [4:0] OP_ADDUW  = 5'd0;
  localparam logic [4:0] OP_SH1    = 5'd1;
  localparam logic [4:0] OP_SH2    = 5'd2;
  localparam logic [4:0] OP_SH3    = 5'd3;
  localparam logic [4:0] OP_SH1UW  = 5'd4;
  localparam logic [4:0] OP_SH2UW  = 5'd5;
  localparam logic [4:0] OP_SH3UW  = 5'd6;
  localparam logic [4:0] OP_SLLIUW = 5'd7;
  localparam logic [4:0] OP_BCLR   = 5'd8;
  localparam logic [4:0] OP_BSET   = 5'd9;
  localparam logic [4:0] OP_BINV   = 5'd10;
  localparam logic [4:0] OP_BEXT   = 5'd11;
  localparam logic [4:0] OP_BCLRI  = 5'd12;
  localparam logic [4:0] OP_BSETI  = 5'd13;
  localparam logic [4:0] OP_BINVI  = 5'd14;
  localparam logic [4:0] OP_BEXTI  = 5'd15;

  always_comb begin
    logic [XLEN-1:0] low_word;
    logic [IDXW-1:0] idx_r, idx_i;
    logic [XLEN-1:0] bit_r, bit_i;
    logic            is_imm;

    low_word = src_a & LOW_MASK;
    idx_r    = src_b[IDXW-1:0];
    idx_i    = imm_amt[IDXW-1:0];
    bit_r    = XLEN'(1) << idx_r;
    bit_i    = XLEN'(1) << idx_i;
    is_imm   = (op_sel == OP_SLLIUW) || (op_sel >= OP_BCLRI && op_sel <= OP_BEXTI);
    reserved_enc = NARROW && is_imm && imm_amt[5];

    unique case (op_sel)
      OP_ADDUW:  result = src_b + low_word;
      OP_SH1:    result = src_b + (src_a << 1);
      OP_SH2:    result = src_b + (src_a << 2);
      OP_SH3:    result = src_b + (src_a << 3);
      OP_SH1UW:  result = src_b + (low_word << 1);
      OP_SH2UW:  result = src_b + (low_word << 2);
      OP_SH3UW:  result = src_b + (low_word << 3);
      OP_SLLIUW: result = low_word << idx_i;
      OP_BCLR:   result = src_a & ~bit_r;
      OP_BSET:   result = src_a | bit_r;
      OP_BINV:   result = src_a ^ bit_r;
      OP_BEXT:   result = XLEN'(src_a[idx_r]);
      OP_BCLRI:  result = src_a & ~bit_i;
      OP_BSETI:  result = src_a | bit_i;
      OP_BINVI:  result = src_a ^ bit_i;
      OP_BEXTI:  result = XLEN'(src_a[idx_i]);
      default:   result = '0;
    endcase
    if (reserved_enc) result = '0;

    if ((op_sel == OP_BCLR || op_sel == OP_BCLRI) && !reserved_enc)
      a_r5_clear_only: assert (((result & ~src_a) == '0) && ($countones(result ^ src_a) <= 1));
    if ((op_sel == OP_BSET || op_sel == OP_BSETI) && !reserved_enc)
      a_r5_set_only: assert (((src_a & ~result) == '0) && ($countones(result ^ src_a) <= 1));
    if ((op_sel == OP_BINV || op_sel == OP_BINVI) && !reserved_enc)
      a_r5_flip_one: assert ($countones(result ^ src_a) == 1);
    if (op_sel == OP_BEXT || op_sel == OP_BEXTI)
      a_r6_bext_lsb: assert (result[XLEN-1:1] == '0);
    if (reserved_enc)
      a_r8_reserved_zero: assert (NARROW && imm_amt[5] && result == '0);
    if (op_sel > OP_BEXTI)
      a_r9_unknown_zero: assert (result == '0 && !reserved_enc);
    if (!NARROW)
      a_r10_wide_no_flag: assert (!reserved_enc);
  end
endmodule

// File: tb/bitmanip_agu_tb.sv
module bitmanip_agu_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  op;
  logic [63:0] a, b;
  logic [5:0]  sh;
  logic [63:0] res64;
  logic        rsv64;
  logic [31:0] res32;
  logic        rsv32;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmanip_agu #(.XLEN(64)) u_dut (
    .op_sel(op), .src_a(a), .src_b(b), .imm_amt(sh),
    .result(res64), .reserved_enc(rsv64));

  bitmanip_agu #(.XLEN(32)) u_dut32 (
    .op_sel(op), .src_a(a[31:0]), .src_b(b[31:0]), .imm_amt(sh),
    .result(res32), .reserved_enc(rsv32));

  typedef struct {
    logic [63:0] e64;
    logic        r64;
    logic [31:0] e32;
    logic        r32;
    string       tag;
  } item_t;

  item_t sb_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;

  task automatic send(input logic [4:0] o, input logic [63:0] va, input logic [63:0] vb,
                      input logic [5:0] s, input logic [63:0] e64, input logic r64,
                      input logic [31:0] e32, input logic r32, input string tag);
    item_t it;
    @(posedge clk);
    op = o; a = va; b = vb; sh = s;
    it.e64 = e64; it.r64 = r64; it.e32 = e32; it.r32 = r32; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_checks++;
      if (res64 !== it.e64 || rsv64 !== it.r64) begin
        n_fail++;
        $display("FAIL %s wide: got %h/%b expected %h/%b", it.tag, res64, rsv64, it.e64, it.r64);
      end
      n_checks++;
      if (res32 !== it.e32 || rsv32 !== it.r32) begin
        n_fail++;
        $display("FAIL %s narrow: got %h/%b expected %h/%b", it.tag, res32, rsv32, it.e32, it.r32);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    op = 5'd0; a = '0; b = '0; sh = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // R3 idle state: zero inputs give a zero sum
    send(5'd0, 64'h0, 64'h0, 6'd0, 64'h0, 0, 32'h0, 0, "R3 idle");
    // R1 shift-and-add
    send(5'd1, 64'h0000_0001_0000_0003, 64'h10, 6'd0, 64'h0000_0002_0000_0016, 0, 32'h16, 0, "R1 sh1");
    send(5'd2, 64'h8000_0000_0000_0001, 64'h5, 6'd0, 64'h9, 0, 32'h9, 0, "R1 sh2 wrap");
    send(5'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8, 6'd0, 64'h0, 0, 32'h0, 0, "R1 sh3 overflow");
    // R2 / R11 zero-extending forms
    send(5'd4, 64'hFFFF_FFFF_8000_0001, 64'h1, 6'd0, 64'h0000_0001_0000_0003, 0, 32'h3, 0, "R2 R11 sh1uw");
    send(5'd5, 64'h1234_5678_0000_0010, 64'h1_0000_0000, 6'd0, 64'h1_0000_0040, 0, 32'h40, 0, "R2 sh2uw");
    send(5'd6, 64'hDEAD_BEEF_FFFF_FFFF, 64'h0, 6'd0, 64'h7_FFFF_FFF8, 0, 32'hFFFF_FFF8, 0, "R2 R11 sh3uw");
    // R3 add.uw
    send(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 6'd0, 64'h1_0000_0000, 0, 32'h0, 0, "R3 adduw carry");
    // R4 / R8 / R10 slli.uw
    send(5'd7, 64'hAAAA_AAAA_8000_0001, 64'h0, 6'd4, 64'h8_0000_0010, 0, 32'h10, 0, "R4 slliuw");
    send(5'd7, 64'hFFFF_0000_0000_0003, 64'h0, 6'd32, 64'h3_0000_0000, 0, 32'h0, 1, "R4 R8 R10 slliuw sh32");
    // R5 / R7 register-index forms
    send(5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'd35, 6'd0, 64'hFFFF_FFF7_FFFF_FFFF, 0, 32'hFFFF_FFF7, 0, "R5 R7 bclr");
    send(5'd9, 64'h0, 64'h7F, 6'd0, 64'h8000_0000_0000_0000, 0, 32'h8000_0000, 0, "R5 R7 bset top");
    send(5'd9, 64'h0, 64'h20, 6'd0, 64'h1_0000_0000, 0, 32'h1, 0, "R7 R8 bset reg no flag");
    send(5'd10, 64'hF0, 64'd4, 6'd0, 64'hE0, 0, 32'hE0, 0, "R5 binv clear");
    send(5'd10, 64'hF0, 64'd9, 6'd0, 64'h2F0, 0, 32'h2F0, 0, "R5 binv set");
    // R6 bext
    send(5'd11, 64'h0000_0010_0000_0000, 64'd36, 6'd0, 64'h1, 0, 32'h0, 0, "R6 R7 bext high");
    send(5'd11, 64'h10, 64'd36, 6'd0, 64'h0, 0, 32'h1, 0, "R6 R7 bext masked");
    // immediate-index forms
    send(5'd12, 64'hFF, 64'h0, 6'd7, 64'h7F, 0, 32'h7F, 0, "R5 bclri");
    send(5'd13, 64'h0, 64'h0, 6'd40, 64'h100_0000_0000, 0, 32'h0, 1, "R5 R8 R10 bseti");
    send(5'd14, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 64'h0, 0, 32'h0, 0, "R5 R7 binvi");
    send(5'd15, 64'h8000_0000_0000_0000, 64'h0, 6'd63, 64'h1, 0, 32'h0, 1, "R6 R8 R10 bexti");
    send(5'd15, 64'h8000_0000, 64'h0, 6'd31, 64'h1, 0, 32'h1, 0, "R6 bexti 31");
    // R9 unknown codes
    send(5'd20, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 6'd63, 64'h0, 0, 32'h0, 0, "R9 unknown");
    send(5'd31, 64'h1234, 64'h5678, 6'd33, 64'h0, 0, 32'h0, 0, "R9 unknown top");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule